// File: doc/BRIEF.md
# Virtual Processor Fetch Gate Controller

This block sits at core level and carries out two privileged instructions that stop and restart the other hardware threads (virtual processors) of a multithreaded core. A "disable" instruction holds instruction fetch for every thread except its issuer and sets a single disable flag in a small control word. An "enable" instruction reverses that, but only while the flag is set. Both instructions return the control word as it was before they ran, sign-extended to register width, to the issuer's register `rt`.

The pipeline presents a decoded-candidate instruction word with a one-cycle `instr_valid` pulse and the issuing thread number. The block decodes the word and holds a recognized instruction as pending. It then waits until the pipeline reports the instruction as the oldest unretired one, so nothing runs speculatively. When the instruction executes, the block updates the per-thread fetch and interrupt enables and raises a one-cycle `retire` pulse. It also raises the write-back port or the coprocessor-unusable flag in that cycle. At the disable event the block records which threads had a PAUSE or a WAIT retired. At the enable, that record decides whether each thread gets fetch back and whether it listens to interrupts again.

Top module: `vpc_core`

## Requirements
- R1: An instruction is recognized only when bits 31:26 are 000000, bits 20:16 are 00000 and bits 5:0 are 111100. Bits 15:6 must be 0011100101 (enable) or 0001100101 (disable), and `rt` is bits 25:21. Any other word with `instr_valid` is ignored: no retire, no write-back and no enable change.
- R2: A recognized instruction takes effect only in a cycle where `is_oldest` is 1. While it is pending with `is_oldest` at 0, `stall` is 1 and no output changes.
- R3: An instruction that takes effect in a cycle produces `retire`=1 for exactly the following cycle. All enable, flag and write-back changes appear at that same clock edge. Fetch enables only ever fall in a retire cycle without exception.
- R4: When the disable flag is 0, disable sets it to 1 and clears `fetch_en` of every thread except the issuer. Each non-issuer that is WAITing at that moment gets `irq_en`=0. When the flag is already 1, disable changes no enable.
- R5: When the flag is 1, enable clears it. Every non-issuer gets `irq_en`=1. Every non-issuer gets `fetch_en`=1, except one whose PAUSE was set at the disable event and whose LL bit is 0 when the enable runs; that thread stays without fetch.
- R6: When the flag is 0, enable changes no enable and leaves the flag at 0.
- R7: When `rt` is nonzero, a non-excepting instruction with multithreading supported writes `wb_data` to register `wb_idx`=`rt`. `wb_data` is the old control word sign-extended: bit 0 is the old disable flag, all other bits are 0. With `rt`=0 there is no write. `wb_idx` and `wb_data` are 0 whenever `wb_en` is 0.
- R8: With `mt_supported`=0 and coprocessor 0 usable, both instructions retire as no-ops. There is no write-back, no exception and no enable change.
- R9: With `cp0_usable`=0, the instruction retires with `cpu_exc`=1. There is no write-back and no state change. This check takes priority over R8.
- R10: After reset every `fetch_en` and `irq_en` bit is 1, the flag is 0, and `retire`, `cpu_exc` and `wb_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | One-cycle pulse presenting `instr_word` |
| instr_word | input | 32 | Instruction word to decode |
| instr_vp | input | VPW | Thread number of the issuer |
| is_oldest | input | 1 | The pending instruction is the oldest unretired one |
| cp0_usable | input | 1 | Coprocessor 0 access enabled |
| mt_supported | input | 1 | Core configured with multithreading |
| vp_paused | input | NUM_VP | Per-thread PAUSE retired |
| vp_waiting | input | NUM_VP | Per-thread WAIT retired |
| vp_llbit | input | NUM_VP | Per-thread LL bit |
| stall | output | 1 | Pending instruction waits for `is_oldest` |
| retire | output | 1 | One-cycle completion pulse |
| cpu_exc | output | 1 | Coprocessor unusable exception |
| fetch_en | output | NUM_VP | Per-thread instruction fetch enable |
| irq_en | output | NUM_VP | Per-thread interrupt enable |
| wb_en | output | 1 | Register write-back strobe |
| wb_idx | output | 5 | Destination register index |
| wb_data | output | XLEN | Old control word, sign-extended |

## Verification
The checks assume that `instr_valid` pulses only when no instruction is pending, or in the very cycle the pending one takes effect. They also assume that the issuing thread itself has fetch enabled, so that fetch enables change only in retire cycles. The bench keeps to this by issuing each instruction as a single pulse. It waits for the retire before the next pulse, except in one back-to-back case that lands exactly on the execution cycle. `vp_paused`, `vp_waiting` and `vp_llbit` are changed only between instructions, so that the values the disable event records are well defined.

// File: rtl/vpc_pkg.sv
package vpc_pkg;

    typedef enum logic [1:0] {
        VOP_NONE = 2'd0,
        VOP_DIS  = 2'd1,
        VOP_ENA  = 2'd2
    } vp_op_e;

    localparam logic [5:0] OPC_MAJOR  = 6'b000000;
    localparam logic [5:0] OPC_MINOR  = 6'b111100;
    localparam logic [9:0] FUNC_ENA   = 10'b0011100101;
    localparam logic [9:0] FUNC_DIS   = 10'b0001100101;
    localparam int         RT_W       = 5;

endpackage

// File: rtl/vpc_decode.sv
module vpc_decode
    import vpc_pkg::*;
(
    input  logic [31:0]     word,
    output vp_op_e          op,
    output logic [RT_W-1:0] rt
);

    logic       frame_ok;
    logic [9:0] func;

    always_comb begin
        func     = word[15:6];
        frame_ok = (word[31:26] == OPC_MAJOR) &&
                   (word[5:0]   == OPC_MINOR) &&
                   (word[20:16] == 5'd0);
        rt       = word[25:21];
        op       = VOP_NONE;
        if (frame_ok) begin
            if (func == FUNC_ENA) begin
                op = VOP_ENA;
            end else if (func == FUNC_DIS) begin
                op = VOP_DIS;
            end
        end
    end

endmodule

// File: rtl/vpc_lane.sv
module vpc_lane (
    input  logic is_issuer,
    input  logic do_dis,
    input  logic do_ena,
    input  logic fetch_q,
    input  logic irq_q,
    input  logic psnap_q,
    input  logic paused_now,
    input  logic waiting_now,
    input  logic llbit_now,
    output logic fetch_d,
    output logic irq_d,
    output logic psnap_d
);

    always_comb begin
        fetch_d = fetch_q;
        irq_d   = irq_q;
        psnap_d = psnap_q;
        if (do_dis) begin
            if (is_issuer) begin
                psnap_d = 1'b0;
            end else begin
                fetch_d = 1'b0;
                irq_d   = !waiting_now;
                psnap_d = paused_now;
            end
        end else if (do_ena) begin
            if (!is_issuer) begin
                fetch_d = !(psnap_q && !llbit_now);
                irq_d   = 1'b1;
                psnap_d = 1'b0;
            end
        end
    end

endmodule

// File: rtl/vpc_core.sv
module vpc_core
    import vpc_pkg::*;
#(
    parameter int NUM_VP = 4,
    parameter int XLEN   = 32,
    parameter int CTL_W  = 8,
    localparam int VPW   = (NUM_VP > 1) ? $clog2(NUM_VP) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [31:0]       instr_word,
    input  logic [VPW-1:0]    instr_vp,
    input  logic              is_oldest,
    input  logic              cp0_usable,
    input  logic              mt_supported,
    input  logic [NUM_VP-1:0] vp_paused,
    input  logic [NUM_VP-1:0] vp_waiting,
    input  logic [NUM_VP-1:0] vp_llbit,
    output logic              stall,
    output logic              retire,
    output logic              cpu_exc,
    output logic [NUM_VP-1:0] fetch_en,
    output logic [NUM_VP-1:0] irq_en,
    output logic              wb_en,
    output logic [RT_W-1:0]   wb_idx,
    output logic [XLEN-1:0]   wb_data
);

    localparam int DIS_BIT = 0;
    localparam int EXT_W   = XLEN - CTL_W;

    typedef struct packed {
        logic              pend;
        vp_op_e            op;
        logic [RT_W-1:0]   rt;
        logic [VPW-1:0]    vp;
        logic [CTL_W-1:0]  ctl;
        logic [NUM_VP-1:0] fetch;
        logic [NUM_VP-1:0] irq;
        logic [NUM_VP-1:0] psnap;
        logic              done;
        logic              exc;
        logic              wb_en;
        logic [RT_W-1:0]   wb_idx;
        logic [XLEN-1:0]   wb_data;
    } state_t;

    state_t s_q, s_d;

    vp_op_e          dec_op;
    logic [RT_W-1:0] dec_rt;

    vpc_decode u_dec (
        .word (instr_word),
        .op   (dec_op),
        .rt   (dec_rt)
    );

    logic fire, can_run, do_dis, do_ena;

    always_comb begin
        fire    = s_q.pend && is_oldest;
        can_run = fire && cp0_usable && mt_supported;
        do_dis  = can_run && (s_q.op == VOP_DIS) && !s_q.ctl[DIS_BIT];
        do_ena  = can_run && (s_q.op == VOP_ENA) &&  s_q.ctl[DIS_BIT];
    end

    logic [NUM_VP-1:0] ln_fetch, ln_irq, ln_psnap;

    for (genvar g = 0; g < NUM_VP; g++) begin : g_lane
        vpc_lane u_lane (
            .is_issuer   (s_q.vp == VPW'(g)),
            .do_dis      (do_dis),
            .do_ena      (do_ena),
            .fetch_q     (s_q.fetch[g]),
            .irq_q       (s_q.irq[g]),
            .psnap_q     (s_q.psnap[g]),
            .paused_now  (vp_paused[g]),
            .waiting_now (vp_waiting[g]),
            .llbit_now   (vp_llbit[g]),
            .fetch_d     (ln_fetch[g]),
            .irq_d       (ln_irq[g]),
            .psnap_d     (ln_psnap[g])
        );
    end

    always_comb begin
        s_d         = s_q;
        s_d.done    = 1'b0;
        s_d.exc     = 1'b0;
        s_d.wb_en   = 1'b0;
        s_d.wb_idx  = '0;
        s_d.wb_data = '0;

        if (fire) begin
            s_d.pend = 1'b0;
            s_d.done = 1'b1;
            if (!cp0_usable) begin
                s_d.exc = 1'b1;
            end else if (mt_supported) begin
                if (s_q.rt != '0) begin
                    s_d.wb_en   = 1'b1;
                    s_d.wb_idx  = s_q.rt;
                    s_d.wb_data = {{EXT_W{s_q.ctl[CTL_W-1]}}, s_q.ctl};
                end
                if (do_dis) begin
                    s_d.ctl[DIS_BIT] = 1'b1;
                end else if (do_ena) begin
                    s_d.ctl[DIS_BIT] = 1'b0;
                end
                s_d.fetch = ln_fetch;
                s_d.irq   = ln_irq;
                s_d.psnap = ln_psnap;
            end
        end

        if (instr_valid && (dec_op != VOP_NONE) && (!s_q.pend || fire)) begin
            s_d.pend = 1'b1;
            s_d.op   = dec_op;
            s_d.rt   = dec_rt;
            s_d.vp   = instr_vp;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q         <= '0;
            s_q.op      <= VOP_NONE;
            s_q.fetch   <= '1;
            s_q.irq     <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign stall    = s_q.pend && !is_oldest;
    assign retire   = s_q.done;
    assign cpu_exc  = s_q.exc;
    assign fetch_en = s_q.fetch;
    assign irq_en   = s_q.irq;
    assign wb_en    = s_q.wb_en;
    assign wb_idx   = s_q.wb_idx;
    assign wb_data  = s_q.wb_data;

endmodule

// File: rtl/vpc_core_chk.sv
module vpc_core_chk #(
    parameter int NUM_VP = 4,
    parameter int XLEN   = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              retire,
    input logic              cpu_exc,
    input logic              wb_en,
    input logic [4:0]        wb_idx,
    input logic [XLEN-1:0]   wb_data,
    input logic [NUM_VP-1:0] fetch_en,
    input logic [NUM_VP-1:0] irq_en,
    input logic              mt_supported,
    input logic              cp0_usable
);

    assert_wb_rt_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> (wb_idx != 5'd0));

    assert_wb_data_flag_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> (wb_data[XLEN-1:1] == '0));

    assert_exc_no_effect_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_exc |-> (retire && !wb_en && $stable(fetch_en) && $stable(irq_en)));

    assert_mt_off_nop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (retire && !$past(mt_supported) && $past(cp0_usable))
            |-> (!wb_en && !cpu_exc && $stable(fetch_en) && $stable(irq_en)));

    for (genvar g = 0; g < NUM_VP; g++) begin : g_lane_chk
        assert_fetch_fall_at_retire_R3: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(fetch_en[g]) |-> (retire && !cpu_exc));
        assert_irq_rise_at_retire_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq_en[g]) |-> retire);
    end

endmodule

bind vpc_core vpc_core_chk #(.NUM_VP(NUM_VP), .XLEN(XLEN)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .retire       (retire),
    .cpu_exc      (cpu_exc),
    .wb_en        (wb_en),
    .wb_idx       (wb_idx),
    .wb_data      (wb_data),
    .fetch_en     (fetch_en),
    .irq_en       (irq_en),
    .mt_supported (mt_supported),
    .cp0_usable   (cp0_usable)
);

// File: tb/vpc_core_tb.sv
module vpc_core_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int N  = 4;
    localparam int XW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          instr_valid = 1'b0;
    logic [31:0]   instr_word = '0;
    logic [1:0]    instr_vp = '0;
    logic          is_oldest = 1'b1;
    logic          cp0_usable = 1'b1;
    logic          mt_supported = 1'b1;
    logic [N-1:0]  vp_paused = '0;
    logic [N-1:0]  vp_waiting = '0;
    logic [N-1:0]  vp_llbit = '0;
    logic          stall, retire, cpu_exc, wb_en;
    logic [N-1:0]  fetch_en, irq_en;
    logic [4:0]    wb_idx;
    logic [XW-1:0] wb_data;

    vpc_core #(.NUM_VP(N), .XLEN(XW), .CTL_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
        .instr_vp(instr_vp), .is_oldest(is_oldest), .cp0_usable(cp0_usable),
        .mt_supported(mt_supported), .vp_paused(vp_paused), .vp_waiting(vp_waiting),
        .vp_llbit(vp_llbit), .stall(stall), .retire(retire), .cpu_exc(cpu_exc),
        .fetch_en(fetch_en), .irq_en(irq_en), .wb_en(wb_en), .wb_idx(wb_idx),
        .wb_data(wb_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;
    string tag = "R10 reset";

    // behavioural reference state
    bit          m_pend;
    int          m_op, m_rt, m_vp;
    bit          m_dis;
    bit [N-1:0]  m_fetch, m_irq, m_ps;
    bit          m_done, m_exc, m_wb;
    int          m_idx;
    logic [31:0] m_data;

    localparam int FN_ENA = 10'h0E5;
    localparam int FN_DIS = 10'h065;

    function automatic logic [31:0] mk(int fn, int rt);
        logic [9:0] f = fn[9:0];
        logic [4:0] r = rt[4:0];
        return {6'b000000, r, 5'b00000, f, 6'b111100};
    endfunction

    function automatic int classify(logic [31:0] w);
        if (w[31:26] != 6'd0 || w[20:16] != 5'd0 || w[5:0] != 6'b111100) return 0;
        if (w[15:6] == 10'h0E5) return 2;
        if (w[15:6] == 10'h065) return 1;
        return 0;
    endfunction

    task automatic chk(bit ok, string t, logic [63:0] act, logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", t, act, exp);
        end
    endtask

    task automatic model_reset();
        m_pend = 0; m_op = 0; m_rt = 0; m_vp = 0; m_dis = 0;
        m_fetch = '1; m_irq = '1; m_ps = '0;
        m_done = 0; m_exc = 0; m_wb = 0; m_idx = 0; m_data = '0;
    endtask

    task automatic model_update();
        bit fire;
        bit old_pend;
        int k;
        old_pend = m_pend;
        fire = m_pend && is_oldest;
        m_done = 0; m_exc = 0; m_wb = 0; m_idx = 0; m_data = '0;
        if (fire) begin
            m_pend = 0;
            m_done = 1;
            if (!cp0_usable) m_exc = 1;
            else if (mt_supported) begin
                if (m_rt != 0) begin
                    m_wb = 1; m_idx = m_rt; m_data = m_dis ? 32'd1 : 32'd0;
                end
                if (m_op == 1 && !m_dis) begin
                    m_dis = 1;
                    for (int i = 0; i < N; i++) begin
                        if (i != m_vp) begin
                            m_fetch[i] = 0;
                            m_irq[i] = !vp_waiting[i];
                            m_ps[i] = vp_paused[i];
                        end else m_ps[i] = 0;
                    end
                end else if (m_op == 2 && m_dis) begin
                    m_dis = 0;
                    for (int i = 0; i < N; i++) begin
                        if (i != m_vp) begin
                            m_fetch[i] = !(m_ps[i] && !vp_llbit[i]);
                            m_irq[i] = 1;
                            m_ps[i] = 0;
                        end
                    end
                end
            end
        end
        k = classify(instr_word);
        if (instr_valid && k != 0 && (!old_pend || fire)) begin
            m_pend = 1; m_op = k; m_rt = int'(instr_word[25:21]); m_vp = int'(instr_vp);
        end
    endtask

    // compare every cycle at the falling edge, then advance the model after the rising edge
    task automatic step();
        @(negedge clk);
        chk({retire, cpu_exc, wb_en, wb_idx, fetch_en, irq_en} ==
            {m_done, m_exc, m_wb, m_idx[4:0], m_fetch, m_irq},
            {tag, " outputs"},
            64'({retire, cpu_exc, wb_en, wb_idx, fetch_en, irq_en}),
            64'({m_done, m_exc, m_wb, m_idx[4:0], m_fetch, m_irq}));
        chk(wb_data == m_data, {tag, " wb_data R7"}, 64'(wb_data), 64'(m_data));
        chk(stall == (m_pend && !is_oldest), {tag, " stall R2"}, 64'(stall),
            64'(m_pend && !is_oldest));
        @(posedge clk);
        #1;
        if (!rst_n) model_reset();
        else model_update();
    endtask

    task automatic issue(int fn, int rt, int vp);
        instr_word = mk(fn, rt);
        instr_vp = vp[1:0];
        instr_valid = 1'b1;
        step();
        instr_valid = 1'b0;
        step();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            fails++;
            tests++;
            $display("FAIL watchdog R3 actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        model_reset();
        #1;
        for (int i = 0; i < 3; i++) step();
        rst_n = 1'b1;
        step();
        chk(fetch_en == 4'hF && irq_en == 4'hF && !retire && !wb_en && !cpu_exc,
            "R10 reset state", 64'({fetch_en, irq_en}), 64'h00FF);

        tag = "R1 decode";
        instr_word = mk(FN_ENA, 3) | 32'h0400_0000;
        instr_valid = 1'b1; step();
        instr_word = mk(10'h0E6, 3); step();
        instr_word = mk(FN_DIS, 3) | 32'h0001_0000; step();
        instr_valid = 1'b0; step(); step();
        chk(!retire && !wb_en && fetch_en == 4'hF, "R1 foreign words ignored",
            64'({retire, wb_en, fetch_en}), 64'h0F);

        tag = "R4 disable";
        vp_waiting = 4'b0100; vp_paused = 4'b1000; vp_llbit = 4'b0000;
        issue(FN_DIS, 5, 1);
        chk(retire && fetch_en == 4'b0010 && irq_en == 4'b1011,
            "R4 disable gates others", 64'({retire, fetch_en, irq_en}), 64'h12B);
        chk(wb_en && wb_idx == 5 && wb_data == 0, "R7 old flag 0 returned",
            64'({wb_en, wb_idx, wb_data}), 64'({1'b1, 5'd5, 32'd0}));
        vp_waiting = '0; vp_paused = '0;
        step();

        tag = "R2 stall";
        is_oldest = 1'b0;
        instr_word = mk(FN_ENA, 7); instr_vp = 2'd1; instr_valid = 1'b1; step();
        instr_valid = 1'b0;
        for (int i = 0; i < 4; i++) step();
        chk(stall && !retire && fetch_en == 4'b0010, "R2 held while not oldest",
            64'({stall, retire, fetch_en}), 64'h22);
        tag = "R5 enable";
        is_oldest = 1'b1; step();
        chk(retire && fetch_en == 4'b0111 && irq_en == 4'hF,
            "R5 paused with LL clear stays off", 64'({retire, fetch_en, irq_en}), 64'h17F);
        chk(wb_en && wb_idx == 7 && wb_data == 1, "R7 old flag 1 returned",
            64'(wb_data), 64'd1);
        step();

        tag = "R6 enable nop";
        issue(FN_ENA, 0, 0);
        chk(retire && !wb_en && fetch_en == 4'b0111, "R6 enable while clear R7 rt0",
            64'({retire, wb_en, fetch_en}), 64'h27);
        step();

        tag = "R9 cp0";
        cp0_usable = 1'b0;
        issue(FN_DIS, 4, 0);
        chk(retire && cpu_exc && !wb_en && fetch_en == 4'b0111, "R9 exception no effect",
            64'({retire, cpu_exc, wb_en, fetch_en}), 64'h67);
        cp0_usable = 1'b1; step();

        tag = "R8 mt off";
        mt_supported = 1'b0;
        issue(FN_DIS, 4, 0);
        chk(retire && !cpu_exc && !wb_en && fetch_en == 4'b0111, "R8 nop without mt",
            64'({retire, cpu_exc, wb_en, fetch_en}), 64'h47);
        mt_supported = 1'b1; step();

        tag = "R4 nested";
        vp_paused = 4'b0010; vp_llbit = 4'b0010;
        issue(FN_DIS, 2, 0);
        chk(fetch_en == 4'b0001 && wb_data == 0, "R4 disable from thread 0",
            64'({fetch_en, wb_data}), 64'h1_0000_0000);
        step();
        issue(FN_DIS, 3, 0);
        chk(fetch_en == 4'b0001 && wb_data == 1, "R4 second disable keeps enables",
            64'({fetch_en, wb_data}), 64'h1_0000_0001);
        step();
        tag = "R5 resume";
        issue(FN_ENA, 1, 0);
        chk(fetch_en == 4'hF && irq_en == 4'hF, "R5 paused with LL set resumes",
            64'({fetch_en, irq_en}), 64'hFF);
        vp_paused = '0; vp_llbit = '0; step();

        tag = "R3 back to back";
        instr_word = mk(FN_DIS, 6); instr_vp = 2'd2; instr_valid = 1'b1; step();
        instr_word = mk(FN_ENA, 8); step();
        instr_valid = 1'b0;
        chk(retire && fetch_en == 4'b0100, "R3 first retire", 64'({retire, fetch_en}), 64'h14);
        step();
        chk(retire && fetch_en == 4'hF && wb_data == 1, "R3 second retire",
            64'({retire, fetch_en}), 64'h1F);
        step(); step();

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule